// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

The block generates four independent pulse-width modulated outputs. A small word-addressed register interface sets them up. Each channel has:

- a 6-bit clock prescaler;
- a 16-bit period count;
- a 16-bit duty count;
- an enable bit, a polarity bit and a drive-type bit.

One period of a channel lasts (prescale+1)·period input clocks. The first (prescale+1)·duty clocks of that period are the active phase.

Software writes the per-channel counts and the shared prescale word, then sets the channel's enable bit. Settings written while a channel runs are taken up only at the next period boundary, so a period is never cut short or stretched by a reconfiguration. Clearing the enable bit stops the channel within one clock. The output then rests at the inactive level, and a later re-enable starts a fresh period from count zero.

The drive-type bits have no effect on the waveform. They are stored, read back and presented on a status port for the pad logic.

Top module: `pwm4_ctrl`

## Requirements
- R1: Every mapped register reads back the value last written, and unused bits read as zero. Writes to unmapped addresses change nothing, and reads of unmapped addresses return zero. The map is as follows:
  - Control at 0x00: bit c is the enable of channel c, bit 8+c its polarity, bit 15+c its drive type.
  - Period of channel c at 0x04+8·c, in bits 15:0.
  - Duty of channel c at 0x08+8·c, in bits 15:0.
  - Prescale word at 0x24.
- R2: After reset the control register reads 0x00000F00 (all channels disabled, all polarities normal). Every other register reads 0 and every output is low.
- R3: In the prescale word, the 6-bit field of channel c sits at bits (3−c)·6+5 down to (3−c)·6. Channel 0 uses bits 23:18 and channel 3 uses bits 5:0.
- R4: A running channel repeats with a period of exactly (prescale+1)·period clocks, for period counts of 2 and above.
- R5: The active phase lasts (prescale+1)·duty clocks at the start of each period. A duty of 0 is never active, and a duty equal to or above the period is active for the whole period.
- R6: With polarity 1 the output is high in the active phase and low otherwise. With polarity 0 the levels are swapped.
- R7: While a channel's enable bit is clear, its output holds the inactive level of its polarity. The output reaches that level one clock after the write that clears the bit.
- R8: Setting a channel's enable bit restarts its prescaler and period count at zero. The output enters the active phase (if the duty is nonzero) one clock after the enabling write.
- R9: Period, duty and prescale values written while a channel runs take effect only at the next period boundary.
- R10: The drive-type bits are stored and read back unchanged, have no effect on the waveform, and appear on the `drive_sel` port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 4 | One PWM output per channel |
| drive_sel | output | 4 | Stored drive-type bit per channel |

## Verification
The bench aims at several corner cases of this block:
- **Prescale field order.** A design that packed the fields in forward order would run channel 0 from bits 5:0, and its period would come out wrong.
- **Duty extremes.** The bench tries duty 0 and duty at or above the period. An off-by-one comparator would show a one-count glitch in these cases.
- **Period change mid-run.** Rewriting the period in the middle of a period would expose a design without shadow registers, because it would cut that period short.
- **Disable and re-enable.** This pair checks that the channel restarts at count zero rather than resuming, and that the output parks at the level its polarity implies.

Seeded random configurations across all channels, prescales and polarities cover the general timing. While one channel runs, the bench also checks that the idle channels stay parked.

// File: rtl/pwm4_pkg.sv
// Shared constants and address helpers for the four-channel PWM controller.
// Assumes byte addressing with word-aligned registers.
package pwm4_pkg;
    localparam int NCH     = 4;
    localparam int PSC_W   = 6;
    localparam int CNT_W   = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int EN_LSB  = 0;
    localparam int POL_LSB = 8;
    localparam int DRV_LSB = 15;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 6'h00;
    localparam logic [ADDR_W-1:0] PSC_OFS  = 6'h24;

    // Byte offset of the period register of channel c.
    function automatic logic [ADDR_W-1:0] per_ofs(input int c);
        return ADDR_W'(4 + 8 * c);
    endfunction

    // Byte offset of the duty register of channel c.
    function automatic logic [ADDR_W-1:0] duty_ofs(input int c);
        return ADDR_W'(8 + 8 * c);
    endfunction

    // Lowest bit of channel c's field in the prescale word (reversed order).
    function automatic int psc_lsb(input int c);
        return (NCH - 1 - c) * PSC_W;
    endfunction
endpackage

// File: rtl/pwm4_regs.sv
// Register file of the PWM controller: control, per-channel period and duty,
// and the packed prescale word. Decodes writes and provides combinational
// read data. Assumes single-cycle write strobes; unmapped addresses read 0.
module pwm4_regs
    import pwm4_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output logic [NCH-1:0]              en,
    output logic [NCH-1:0]              pol,
    output logic [NCH-1:0]              drv,
    output logic [NCH-1:0][PSC_W-1:0]   psc,
    output logic [NCH-1:0][CNT_W-1:0]   per,
    output logic [NCH-1:0][CNT_W-1:0]   duty
);
    // Register update on reset or decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= '0;
            pol  <= '1;
            drv  <= '0;
            psc  <= '0;
            per  <= '0;
            duty <= '0;
        end else if (wr_en) begin
            if (addr == CTRL_OFS) begin
                en  <= wdata[EN_LSB  +: NCH];
                pol <= wdata[POL_LSB +: NCH];
                drv <= wdata[DRV_LSB +: NCH];
            end
            if (addr == PSC_OFS) begin
                for (int c = 0; c < NCH; c++) psc[c] <= wdata[psc_lsb(c) +: PSC_W];
            end
            for (int c = 0; c < NCH; c++) begin
                if (addr == per_ofs(c))  per[c]  <= wdata[CNT_W-1:0];
                if (addr == duty_ofs(c)) duty[c] <= wdata[CNT_W-1:0];
            end
        end
    end

    // Read multiplexer; unmapped addresses and unused bits give zero.
    always_comb begin
        rdata = '0;
        if (addr == CTRL_OFS) begin
            rdata[EN_LSB  +: NCH] = en;
            rdata[POL_LSB +: NCH] = pol;
            rdata[DRV_LSB +: NCH] = drv;
        end
        if (addr == PSC_OFS) begin
            for (int c = 0; c < NCH; c++) rdata[psc_lsb(c) +: PSC_W] = psc[c];
        end
        for (int c = 0; c < NCH; c++) begin
            if (addr == per_ofs(c))  rdata[CNT_W-1:0] = per[c];
            if (addr == duty_ofs(c)) rdata[CNT_W-1:0] = duty[c];
        end
    end

    // R3
    psc_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == PSC_OFS) |-> psc[0] == $past(wdata[23:18]) && psc[NCH-1] == $past(wdata[5:0]));
endmodule

// File: rtl/pwm4_chan.sv
// One PWM channel: prescaler, period counter, shadowed settings and output
// level. Settings are captured on start and at each period wrap, so a
// running period is never altered. Assumes period counts of 2 or more.
module pwm4_chan #(
    parameter int PSC_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pol,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm_o
);
    localparam int EXT_W = CNT_W + 1;

    logic             run;
    logic [PSC_W-1:0] psc_cnt, sh_psc;
    logic [CNT_W-1:0] per_cnt, sh_per, sh_duty;
    logic             tick, per_last, active;

    assign tick     = (psc_cnt == sh_psc);
    assign per_last = (EXT_W'(per_cnt) + EXT_W'(1)) >= EXT_W'(sh_per);

    // Counter and shadow sequencing: stop, start, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            psc_cnt <= '0;
            per_cnt <= '0;
            sh_psc  <= '0;
            sh_per  <= '0;
            sh_duty <= '0;
        end else if (!en) begin
            run     <= 1'b0;
            psc_cnt <= '0;
            per_cnt <= '0;
        end else if (!run) begin
            run     <= 1'b1;
            psc_cnt <= '0;
            per_cnt <= '0;
            sh_psc  <= psc_in;
            sh_per  <= per_in;
            sh_duty <= duty_in;
        end else if (tick) begin
            psc_cnt <= '0;
            if (per_last) begin
                per_cnt <= '0;
                sh_psc  <= psc_in;
                sh_per  <= per_in;
                sh_duty <= duty_in;
            end else begin
                per_cnt <= per_cnt + 1'b1;
            end
        end else begin
            psc_cnt <= psc_cnt + 1'b1;
        end
    end

    // Output level from phase and polarity.
    assign active = run && (per_cnt < sh_duty);
    assign pwm_o  = active ? pol : ~pol;

    // R4
    presc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> psc_cnt <= sh_psc);
    // R4
    per_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sh_per >= 2) |-> per_cnt < sh_per);
    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> psc_cnt == '0 && per_cnt == '0);
    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick && per_last)) |->
        ($stable(sh_per) && $stable(sh_duty) && $stable(sh_psc)));
endmodule

// File: rtl/pwm4_ctrl.sv
// Top of the four-channel prescaled PWM controller. Connects the register
// file to one channel instance per output and exposes the stored drive-type
// bits. Assumes a synchronous single-clock environment.
module pwm4_ctrl
    import pwm4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    drive_sel
);
    logic [NCH-1:0]            en_w, pol_w, drv_w;
    logic [NCH-1:0][PSC_W-1:0] psc_w;
    logic [NCH-1:0][CNT_W-1:0] per_w, duty_w;

    pwm4_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .en(en_w), .pol(pol_w), .drv(drv_w),
        .psc(psc_w), .per(per_w), .duty(duty_w)
    );

    assign drive_sel = drv_w;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm4_chan #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en_w[c]), .pol(pol_w[c]),
            .psc_in(psc_w[c]), .per_in(per_w[c]), .duty_in(duty_w[c]),
            .pwm_o(pwm_out[c])
        );

        // R7
        disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en_w[c]) |-> pwm_out[c] == ~pol_w[c]);
    end
endmodule

// File: tb/tb_pwm4_ctrl.sv
module tb_pwm4_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out, drive_sel;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] psc_word = '0;

    pwm4_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                   .rdata(rdata), .pwm_out(pwm_out), .drive_sel(drive_sel));

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    function automatic logic exp_out(int k, int p, int per, int duty, logic pol);
        int len = (p + 1) * per;
        int act_len = (p + 1) * ((duty < per) ? duty : per);
        return ((k % len) < act_len) ? pol : ~pol;
    endfunction

    // Configure one channel, enable it, compare ncyc cycles and idle outputs.
    task automatic run_ch(input string req, input int ch, input int p, input int per,
                          input int duty, input logic [3:0] pv, input int ncyc);
        int bad = 0, idle_bad = 0;
        psc_word[(3-ch)*6 +: 6] = 6'(p);
        wr(6'h24, psc_word);
        wr(6'(4 + 8*ch), 32'(per));
        wr(6'(8 + 8*ch), 32'(duty));
        wr(6'h00, {20'd0, pv, 8'd0});
        wr(6'h00, {20'd0, pv, 4'd0, 4'(1 << ch)});
        @(posedge clk);
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (pwm_out[ch] !== exp_out(k, p, per, duty, pv[ch])) bad++;
            for (int o = 0; o < 4; o++)
                if (o != ch && pwm_out[o] !== ~pv[o]) idle_bad++;
        end
        check(req, 32'(bad), 0);
        check("R7 idle channels", 32'(idle_bad), 0);
        wr(6'h00, {20'd0, pv, 8'd0});
        @(posedge clk); @(negedge clk);
        check("R7 stop", {31'd0, pwm_out[ch]}, {31'd0, ~pv[ch]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset state
        rd(6'h00, d); check("R2 ctrl", d, 32'h0000_0F00);
        rd(6'h24, d); check("R2 prescale", d, 0);
        rd(6'h04, d); check("R2 period0", d, 0);
        check("R2 outputs", {28'd0, pwm_out}, 0);

        // R1 readback, reserved bits, unmapped
        wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, d); check("R1 prescale mask", d, 32'h00FF_FFFF);
        wr(6'h14, 32'hABCD_1234); rd(6'h14, d); check("R1 period2", d, 32'h0000_1234);
        wr(6'h20, 32'h5555_8765); rd(6'h20, d); check("R1 duty3", d, 32'h0000_8765);
        wr(6'h28, 32'hFFFF_FFFF); rd(6'h28, d); check("R1 unmapped read", d, 0);
        rd(6'h14, d); check("R1 unmapped write ignored", d, 32'h0000_1234);

        // R10 drive-type bits
        wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, d); check("R1 ctrl mask", d, 32'h0007_8F0F);
        check("R10 drive_sel", {28'd0, drive_sel}, 32'hF);
        wr(6'h00, 32'h0002_8F00); rd(6'h00, d); check("R10 ctrl readback", d, 32'h0002_8F00);
        check("R10 drive_sel partial", {28'd0, drive_sel}, 32'h5);

        // R3 field order: channel 0 at 23:18, channel 3 at 5:0
        psc_word = 32'h0;
        wr(6'h24, 32'h0008_0000); rd(6'h24, d); check("R3 pack", d, 32'h0008_0000);
        psc_word = 32'h0008_0000;
        run_ch("R3 ch0 field", 0, 2, 4, 2, 4'hF, 30);
        run_ch("R3 ch3 field", 3, 3, 3, 1, 4'hF, 30);

        // R5 duty extremes, R6 polarity, R8 restart
        run_ch("R5 duty zero", 1, 0, 5, 0, 4'hF, 12);
        run_ch("R5 duty above period", 2, 1, 4, 9, 4'hF, 12);
        run_ch("R5 duty equals period", 2, 0, 6, 6, 4'hF, 12);
        run_ch("R6 inverted", 0, 0, 5, 2, 4'h0, 12);
        run_ch("R8 restart", 0, 1, 7, 3, 4'h1, 20);

        // R9 period changed mid-run applies after the current period
        begin
            int bad = 0;
            psc_word[23:18] = 6'd0;
            wr(6'h24, psc_word);
            wr(6'h04, 32'd10); wr(6'h08, 32'd5);
            wr(6'h00, 32'h0000_0F01);
            @(posedge clk);
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (pwm_out[0] !== ((k < 10) ? (k < 5) : 1'b1)) bad++;
                if (k == 3) begin addr = 6'h04; wdata = 32'd4; wr_en = 1'b1; end
                if (k == 4) wr_en = 1'b0;
            end
            check("R9 shadowed period", 32'(bad), 0);
            wr(6'h00, 32'h0000_0F00);
        end

        // R4 R6 random configurations
        for (int t = 0; t < 20; t++) begin
            int ch = $urandom % 4;
            int p = $urandom % 4;
            int per = 2 + $urandom % 19;
            int duty = $urandom % 24;
            logic [3:0] pv = 4'($urandom);
            run_ch("R4 random period", ch, p, per, duty, pv, 2 * (p + 1) * per + 3);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule